// File: doc/BRIEF.md
# Serial Flash Read Phase Sequencer

This block steps a serial flash read through its phases once the opcode has been decoded. It collects the address one bit at a time from the deserializer. The address is 24 or 32 bits wide. The block then passes through an optional mode-byte phase and a dummy phase, which the command selects. After that it enters the data phase. In the data phase a bit pacer counts the serial cycles of each byte from the lane width. At every byte boundary the running address advances by one and a memory read request for the following byte is issued.

The read buffer is split into halves of 2^BUF_BITS bytes. A one-cycle pulse marks the byte on which the current half ends. Requests whose address falls inside a configurable window are flagged so that the memory side can serve them from that window. A software-visible copy of the address is captured on request, under a set of guarding conditions. The block is reset between commands by its active-low reset. The external memory and the output shifter lie outside this block.

Top module: `flash_rd_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, the block behaves as follows:
  - `phase_o` reads 0 (idle).
  - `rd_req_o` and `flip_o` are low.
  - `addr_o` and `latched_addr_o` are zero.
  - The phase codes are: 0 idle, 1 address, 2 mode byte, 3 dummy, 4 data, 5 error.
- R2: The block leaves idle for the address phase (code 1) only when `path_sel_i` is 2'b01 (normal read) or 2'b10 (parameter read). With 2'b00 or 2'b11 it stays idle and issues no request.
- R3: In the address phase, each cycle with `s2p_valid_i` high shifts in `s2p_data_i[0]`, most significant bit first.
  - The phase takes 32 bits when `addr4_i` is 1 and 24 bits when it is 0.
  - In the cycle of the last bit, `rd_req_o` is high and `rd_addr_o` equals the assembled address.
- R4: After the last address bit, the next phase is chosen by {`mode_byte_en_i`, `dummy_en_i`}:
  - 00 goes straight to data.
  - 01 goes to dummy for `dummy_len_i`+1 cycles.
  - 1x goes to mode byte, which waits for one valid byte and stores it on `mode_byte_o`. Dummy then follows, lasting `dummy_len_i`+1 cycles if `dummy_en_i` is 1 and 1 cycle otherwise.
- R5: `lanes_i` sets the cycles per data byte: 4'b0010 gives 8 cycles, 4'b0011 gives 4 and 4'b1111 gives 2. Any other value at the end of the address sends the block to the error phase (code 5). It stays there until reset and issues no request.
- R6: In the data phase `addr_o` holds the address of the byte being sent. In the last cycle of each byte, `rd_req_o` is high with `rd_addr_o` = `addr_o`+1, and the address advances on the next edge. The address never advances outside the data phase.
- R7: `flip_o` is high exactly in the last cycle of a byte whose address has its low BUF_BITS bits all ones.
- R8: A pulse on `latch_en_i` in the data phase copies `addr_o` into `latched_addr_o` on the next edge. This happens only if all of the following hold; otherwise the pulse has no effect:
  - `path_sel_i` is 2'b01.
  - `flash_mode_i` is 1.
  - The window check does not apply: either `win_en_i` is 0 or `addr_o` is outside the window.
- R9: An address lies in the window when it matches `win_base_i` in every bit above WIN_BITS.
  - `rd_mbx_o` is high with a request when `win_en_i`, `intercept_en_i` and a window hit on `rd_addr_o` all hold.
  - `mbx_active_o` holds the value of the last request's flag until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, also the end-of-command reset |
| path_sel_i | input | 2 | Datapath select: 01 normal read, 10 parameter read |
| flash_mode_i | input | 1 | Flash mode active |
| addr4_i | input | 1 | 1 selects a 32-bit address, 0 a 24-bit address |
| mode_byte_en_i | input | 1 | Command has a mode byte |
| dummy_en_i | input | 1 | Command has dummy cycles |
| dummy_len_i | input | DUMMY_W | Dummy cycles minus one |
| lanes_i | input | 4 | Data lane enable code |
| s2p_valid_i | input | 1 | Deserializer strobe |
| s2p_data_i | input | 8 | Deserializer data; bit 0 carries address bits |
| latch_en_i | input | 1 | Request to capture the current address |
| win_en_i | input | 1 | Window matching enabled |
| intercept_en_i | input | 1 | Redirect window hits to the window memory |
| win_base_i | input | 32 | Window base address |
| addr_o | output | 32 | Running byte address |
| rd_req_o | output | 1 | Memory read request |
| rd_addr_o | output | 32 | Address of the requested byte |
| rd_mbx_o | output | 1 | Request is served from the window |
| mbx_active_o | output | 1 | Flag of the last request |
| flip_o | output | 1 | Read buffer half finished |
| latched_addr_o | output | 32 | Captured address |
| mode_byte_o | output | 8 | Captured mode byte |
| phase_o | output | 3 | Current phase code |

## Verification
The byte boundary is where several functions meet in one cycle:
- the request for the next byte,
- the address step,
- the buffer-flip pulse,
- the window flag.

The bench starts reads just below a multiple of 1024, and also just below the edge of the window. This makes the flip and a change of window membership land on the same boundary as a request. A software latch pulse can also coincide with the final cycle of a byte. The bench drives such a pulse there and checks that the copy holds the byte still being sent, not the advanced address. Every case is judged against addresses and flags that the bench computes itself.

// File: rtl/frs_pkg.sv
`timescale 1ns/1ps
package frs_pkg;

  localparam int FRS_AW = 32;
  localparam int FRS_CW = 5;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_MODE = 3'd2,
    ST_WAIT = 3'd3,
    ST_DATA = 3'd4,
    ST_ERR  = 3'd5
  } frs_state_e;

  localparam logic [1:0] PATH_READ  = 2'b01;
  localparam logic [1:0] PATH_PARAM = 2'b10;

  localparam logic [3:0] LANE_X1 = 4'b0010;
  localparam logic [3:0] LANE_X2 = 4'b0011;
  localparam logic [3:0] LANE_X4 = 4'b1111;

  // true when the lane code is one of the three supported widths
  function automatic logic lane_ok(input logic [3:0] code);
    return (code == LANE_X1) || (code == LANE_X2) || (code == LANE_X4);
  endfunction

  // bit pacer start value: cycles per byte minus one
  function automatic logic [2:0] lane_reload(input logic [3:0] code);
    logic [2:0] r;
    case (code)
      LANE_X1: r = 3'd7;
      LANE_X2: r = 3'd3;
      LANE_X4: r = 3'd1;
      default: r = 3'd0;
    endcase
    return r;
  endfunction

  // address bit counter start value: address bits minus one
  function automatic logic [FRS_CW-1:0] addr_first(input logic wide);
    return wide ? FRS_CW'(31) : FRS_CW'(23);
  endfunction

endpackage

// File: rtl/frs_addr_unit.sv
`timescale 1ns/1ps
module frs_addr_unit
  import frs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              wide_i,
  input  logic              shift_en_i,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  input  logic              inc_i,
  output logic [FRS_AW-1:0] addr_o,
  output logic [FRS_AW-1:0] addr_next_o,
  output logic              last_o
);

  logic [FRS_CW-1:0] cnt_q;
  logic [FRS_AW-1:0] addr_q, addr_d;
  logic              take;

  assign take   = shift_en_i && bit_vld_i;
  assign last_o = take && (cnt_q == '0);

  always_comb begin
    addr_d = addr_q;
    if (clear_i)     addr_d = '0;
    else if (take)   addr_d = {addr_q[FRS_AW-2:0], bit_i};
    else if (inc_i)  addr_d = addr_q + FRS_AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      addr_q <= addr_d;
      if (clear_i)                   cnt_q <= addr_first(wide_i);
      else if (take && cnt_q != '0)  cnt_q <= cnt_q - FRS_CW'(1);
    end
  end

  assign addr_o      = addr_q;
  assign addr_next_o = addr_d;

  // R6: shifting and stepping are never requested together
  a_r6_shift_inc_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && inc_i));

endmodule

// File: rtl/frs_bit_pacer.sv
`timescale 1ns/1ps
module frs_bit_pacer
  import frs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic       run_i,
  input  logic [3:0] lanes_i,
  output logic [2:0] cnt_o,
  output logic       byte_end_o
);

  logic [2:0] cnt_q;

  assign byte_end_o = run_i && (cnt_q == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load_i)     cnt_q <= lane_reload(lanes_i);
    else if (run_i)      cnt_q <= (cnt_q == 3'd0) ? lane_reload(lanes_i) : cnt_q - 3'd1;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/frs_win_match.sv
`timescale 1ns/1ps
module frs_win_match #(
  parameter int AW       = 32,
  parameter int WIN_BITS = 10
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] base_i,
  output logic          hit_o
);

  localparam logic [AW-1:0] LOW_MASK = {{(AW-WIN_BITS){1'b0}}, {WIN_BITS{1'b1}}};

  assign hit_o = ((addr_i ^ base_i) & ~LOW_MASK) == '0;

endmodule

// File: rtl/flash_rd_seq.sv
`timescale 1ns/1ps
module flash_rd_seq
  import frs_pkg::*;
#(
  parameter int BUF_BITS = 10,
  parameter int WIN_BITS = 10,
  parameter int DUMMY_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         path_sel_i,
  input  logic               flash_mode_i,
  input  logic               addr4_i,
  input  logic               mode_byte_en_i,
  input  logic               dummy_en_i,
  input  logic [DUMMY_W-1:0] dummy_len_i,
  input  logic [3:0]         lanes_i,
  input  logic               s2p_valid_i,
  input  logic [7:0]         s2p_data_i,
  input  logic               latch_en_i,
  input  logic               win_en_i,
  input  logic               intercept_en_i,
  input  logic [31:0]        win_base_i,
  output logic [31:0]        addr_o,
  output logic               rd_req_o,
  output logic [31:0]        rd_addr_o,
  output logic               rd_mbx_o,
  output logic               mbx_active_o,
  output logic               flip_o,
  output logic [31:0]        latched_addr_o,
  output logic [7:0]         mode_byte_o,
  output logic [2:0]         phase_o
);

  frs_state_e         st_q, st_d;
  logic               in_idle, in_addr, in_data, enter_data;
  logic               addr_done, byte_end, lanes_good, req;
  logic               hit_next, hit_cur, latch_fire, mbx_q;
  logic [FRS_AW-1:0]  addr_q, addr_nx, lat_q;
  logic [2:0]         bit_cnt;
  logic [DUMMY_W-1:0] dcnt_q;
  logic [7:0]         mbyte_q;

  assign in_idle    = (st_q == ST_IDLE);
  assign in_addr    = (st_q == ST_ADDR);
  assign in_data    = (st_q == ST_DATA);
  assign lanes_good = lane_ok(lanes_i);

  frs_addr_unit u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (in_idle),
    .wide_i      (addr4_i),
    .shift_en_i  (in_addr),
    .bit_vld_i   (s2p_valid_i),
    .bit_i       (s2p_data_i[0]),
    .inc_i       (byte_end),
    .addr_o      (addr_q),
    .addr_next_o (addr_nx),
    .last_o      (addr_done)
  );

  frs_bit_pacer u_pacer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (enter_data),
    .run_i      (in_data),
    .lanes_i    (lanes_i),
    .cnt_o      (bit_cnt),
    .byte_end_o (byte_end)
  );

  frs_win_match #(.AW(FRS_AW), .WIN_BITS(WIN_BITS)) u_win_next (
    .addr_i (addr_nx),
    .base_i (win_base_i),
    .hit_o  (hit_next)
  );

  frs_win_match #(.AW(FRS_AW), .WIN_BITS(WIN_BITS)) u_win_cur (
    .addr_i (addr_q),
    .base_i (win_base_i),
    .hit_o  (hit_cur)
  );

  // phase sequencing
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (path_sel_i == PATH_READ || path_sel_i == PATH_PARAM) st_d = ST_ADDR;
      ST_ADDR: begin
        if (addr_done) begin
          if (!lanes_good) st_d = ST_ERR;
          else begin
            case ({mode_byte_en_i, dummy_en_i})
              2'b00:   st_d = ST_DATA;
              2'b01:   st_d = ST_WAIT;
              default: st_d = ST_MODE;
            endcase
          end
        end
      end
      ST_MODE: if (s2p_valid_i) st_d = ST_WAIT;
      ST_WAIT: if (dcnt_q == '0) st_d = ST_DATA;
      ST_DATA: st_d = ST_DATA;
      ST_ERR:  st_d = ST_ERR;
      default: st_d = ST_ERR;
    endcase
  end

  assign enter_data = (st_d == ST_DATA) && !in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // dummy counter: loaded when the address completes, counts down in dummy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              dcnt_q <= '0;
    else if (addr_done)                      dcnt_q <= dummy_en_i ? dummy_len_i : '0;
    else if (st_q == ST_WAIT && dcnt_q != '0) dcnt_q <= dcnt_q - DUMMY_W'(1);
  end

  // mode byte capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             mbyte_q <= '0;
    else if (st_q == ST_MODE && s2p_valid_i) mbyte_q <= s2p_data_i;
  end

  // requests: first at address completion, then one per byte boundary
  assign req = (addr_done && lanes_good) || byte_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mbx_q <= 1'b0;
    else if (req)   mbx_q <= rd_mbx_o;
  end

  // software copy of the address
  assign latch_fire = in_data && (path_sel_i == PATH_READ) && latch_en_i &&
                      flash_mode_i && !(win_en_i && hit_cur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lat_q <= '0;
    else if (latch_fire) lat_q <= addr_q;
  end

  assign addr_o         = addr_q;
  assign rd_req_o       = req;
  assign rd_addr_o      = addr_nx;
  assign rd_mbx_o       = req && win_en_i && intercept_en_i && hit_next;
  assign mbx_active_o   = mbx_q;
  assign flip_o         = byte_end && (&addr_q[BUF_BITS-1:0]);
  assign latched_addr_o = lat_q;
  assign mode_byte_o    = mbyte_q;
  assign phase_o        = st_q;

  // R6: no address step during the address phase
  a_r6_no_step_in_addr: assert property (@(posedge clk) disable iff (!rst_n)
    in_addr |-> !byte_end);

  // R5: error phase is left only by reset
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ERR) |=> (st_q == ST_ERR));

  // R5: pacer starts a full byte on data entry
  a_r5_reload_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && $past(st_q) != ST_DATA) |-> (bit_cnt == lane_reload(lanes_i)));

  // R7: flip only with a boundary request in data phase
  a_r7_flip_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    flip_o |-> (in_data && rd_req_o));

  // R8: copy changes only after a latch pulse in data phase
  a_r8_latch_source: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(latched_addr_o) |-> ($past(st_q) == ST_DATA && $past(latch_en_i)));

  // R2: idle is held for unsupported datapath codes
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && path_sel_i != PATH_READ && path_sel_i != PATH_PARAM) |=> (st_q == ST_IDLE));

endmodule

// File: tb/flash_rd_seq_bench.sv
`timescale 1ns/1ps
module flash_rd_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  path_sel = 2'b00;
  logic        flash_mode = 1'b1;
  logic        addr4 = 1'b0;
  logic        mb_en = 1'b0;
  logic        dm_en = 1'b0;
  logic [2:0]  dlen = 3'd0;
  logic [3:0]  lanes = 4'b0010;
  logic        s_vld = 1'b0;
  logic [7:0]  s_dat = 8'h00;
  logic        latch_en = 1'b0;
  logic        win_en = 1'b0;
  logic        icpt_en = 1'b0;
  logic [31:0] win_base = 32'h0;

  logic [31:0] addr_o, rd_addr_o, latched_o;
  logic        rd_req_o, rd_mbx_o, mbx_act_o, flip_o;
  logic [7:0]  mbyte_o;
  logic [2:0]  phase_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flash_rd_seq u_flash_rd_seq (
    .clk(clk), .rst_n(rst_n), .path_sel_i(path_sel), .flash_mode_i(flash_mode),
    .addr4_i(addr4), .mode_byte_en_i(mb_en), .dummy_en_i(dm_en), .dummy_len_i(dlen),
    .lanes_i(lanes), .s2p_valid_i(s_vld), .s2p_data_i(s_dat), .latch_en_i(latch_en),
    .win_en_i(win_en), .intercept_en_i(icpt_en), .win_base_i(win_base),
    .addr_o(addr_o), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_mbx_o(rd_mbx_o),
    .mbx_active_o(mbx_act_o), .flip_o(flip_o), .latched_addr_o(latched_o),
    .mode_byte_o(mbyte_o), .phase_o(phase_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int per_byte(input logic [3:0] l);
    if (l == 4'b0010) return 8;
    if (l == 4'b0011) return 4;
    if (l == 4'b1111) return 2;
    return 0;
  endfunction

  function automatic bit in_win(input logic [31:0] x);
    return ((x >> 10) == (win_base >> 10));
  endfunction

  function automatic bit mbx_exp(input logic [31:0] x);
    return win_en && icpt_en && in_win(x);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    s_vld = 1'b0;
    latch_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  // one full read; latch pulse at output cycle index lat_at (-1 for none)
  task automatic run_read(input logic [31:0] a, input int nbytes, input int lat_at);
    int nb;
    int cpb;
    int dexp;
    int dseen;
    logic [31:0] exp_lat;
    nb = addr4 ? 32 : 24;
    cpb = per_byte(lanes);
    do_reset();
    chk(phase_o == 3'd0, "R1 phase", 32'(phase_o), 0);
    chk(!rd_req_o && !flip_o, "R1 outputs", {30'd0, rd_req_o, flip_o}, 0);
    chk(addr_o == 0 && latched_o == 0, "R1 addr", addr_o | latched_o, 0);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      s_vld = 1'b1;
      s_dat = {7'd0, a[nb-1-i]};
      #1;
      if (i == 0) chk(phase_o == 3'd1, "R2 enter address", 32'(phase_o), 1);
      if (i == nb - 1) begin
        chk(rd_req_o == (cpb != 0), "R3 request at last bit", 32'(rd_req_o), 32'(cpb != 0));
        chk(rd_addr_o == a, "R3 assembled address", rd_addr_o, a);
        chk(rd_mbx_o == (mbx_exp(a) && cpb != 0), "R9 first flag", 32'(rd_mbx_o), 32'(mbx_exp(a)));
      end else begin
        chk(!rd_req_o, "R3 no early request", 32'(rd_req_o), 0);
      end
    end
    if (cpb == 0) begin
      for (int j = 0; j < 4; j++) begin
        @(negedge clk);
        s_vld = 1'b0;
        #1;
        chk(phase_o == 3'd5, "R5 error sticky", 32'(phase_o), 5);
        chk(!rd_req_o, "R5 no request in error", 32'(rd_req_o), 0);
      end
      return;
    end
    if (mb_en) begin
      @(negedge clk);
      s_vld = 1'b0;
      #1;
      chk(phase_o == 3'd2, "R4 mode byte wait", 32'(phase_o), 2);
      @(negedge clk);
      s_vld = 1'b1;
      s_dat = 8'hA5 ^ a[7:0];
      #1;
      chk(phase_o == 3'd2, "R4 mode byte take", 32'(phase_o), 2);
    end
    @(negedge clk);
    s_vld = 1'b0;
    #1;
    if (mb_en) chk(mbyte_o == (8'hA5 ^ a[7:0]), "R4 mode byte value", 32'(mbyte_o), 32'(8'hA5 ^ a[7:0]));
    dexp = mb_en ? (dm_en ? int'(dlen) + 1 : 1) : (dm_en ? int'(dlen) + 1 : 0);
    dseen = 0;
    while (phase_o == 3'd3 && dseen < 20) begin
      dseen++;
      @(negedge clk);
      #1;
    end
    chk(dseen == dexp, "R4 dummy length", 32'(dseen), 32'(dexp));
    chk(phase_o == 3'd4, "R4 data phase", 32'(phase_o), 4);
    exp_lat = 32'h0;
    for (int k = 0; k < nbytes; k++) begin
      for (int c = 0; c < cpb; c++) begin
        logic [31:0] cur;
        cur = a + 32'(k);
        if (!(k == 0 && c == 0)) @(negedge clk);
        latch_en = (k * cpb + c == lat_at);
        #1;
        chk(latched_o == exp_lat, "R8 latched value", latched_o, exp_lat);
        chk(addr_o == cur, "R6 running address", addr_o, cur);
        if (c == 0) chk(mbx_act_o == mbx_exp(cur), "R9 active flag", 32'(mbx_act_o), 32'(mbx_exp(cur)));
        if (c == cpb - 1) begin
          chk(rd_req_o && rd_addr_o == cur + 1, "R6 boundary request", rd_addr_o, cur + 1);
          chk(flip_o == (cur[9:0] == 10'h3FF), "R7 flip", 32'(flip_o), 32'(cur[9:0] == 10'h3FF));
          chk(rd_mbx_o == mbx_exp(cur + 1), "R9 request flag", 32'(rd_mbx_o), 32'(mbx_exp(cur + 1)));
        end else begin
          chk(!rd_req_o && !flip_o, "R5 mid-byte quiet", {30'd0, rd_req_o, flip_o}, 0);
        end
        if (latch_en && path_sel == 2'b01 && flash_mode && !(win_en && in_win(cur))) exp_lat = cur;
      end
    end
    @(negedge clk);
    latch_en = 1'b0;
    #1;
    chk(latched_o == exp_lat, "R8 final latched", latched_o, exp_lat);
  endtask

  task automatic idle_hold(input logic [1:0] p);
    do_reset();
    path_sel = p;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      s_vld = 1'b1;
      s_dat = 8'h01;
      #1;
      chk(phase_o == 3'd0 && !rd_req_o, "R2 idle hold", 32'(phase_o), 0);
    end
    s_vld = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [3:0] lane_set [3];
    lane_set[0] = 4'b0010;
    lane_set[1] = 4'b0011;
    lane_set[2] = 4'b1111;
    path_sel = 2'b01;
    // sweep: lane width x address length x phase routing, across a flip
    for (int l = 0; l < 3; l++) begin
      for (int w = 0; w < 2; w++) begin
        for (int r = 0; r < 4; r++) begin
          lanes = lane_set[l];
          addr4 = w[0];
          mb_en = r[1];
          dm_en = r[0];
          dlen  = 3'(l * 2 + r);
          run_read(w[0] ? 32'hC0DE_07FD : 32'h0012_3BFE, 5, 3);
        end
      end
    end
    mb_en = 1'b0;
    dm_en = 1'b0;
    addr4 = 1'b0;
    // latch on the last cycle of a byte captures the byte being sent
    lanes = 4'b0011;
    run_read(32'h0000_1234, 3, 7);
    // parameter read: flows, but never latches
    path_sel = 2'b10;
    run_read(32'h0000_0100, 3, 2);
    path_sel = 2'b01;
    // flash mode off: latch ignored
    flash_mode = 1'b0;
    run_read(32'h0000_0200, 2, 1);
    flash_mode = 1'b1;
    // window with interception: flags flip at the window edge, latch blocked
    win_en = 1'b1;
    icpt_en = 1'b1;
    win_base = 32'h0000_4000;
    lanes = 4'b1111;
    run_read(32'h0000_43FE, 4, 1);
    // window without interception: no flags, latch still blocked
    icpt_en = 1'b0;
    run_read(32'h0000_4010, 2, 0);
    // window enabled, address outside: latch allowed
    run_read(32'h0000_8010, 2, 1);
    win_en = 1'b0;
    // invalid lane code
    lanes = 4'b0001;
    run_read(32'h0000_0042, 1, -1);
    lanes = 4'b0010;
    dm_en = 1'b1;
    lanes = 4'b0100;
    run_read(32'h0000_0043, 1, -1);
    lanes = 4'b0010;
    dm_en = 1'b0;
    // unsupported datapath codes
    idle_hold(2'b00);
    idle_hold(2'b11);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule